// File: doc/BRIEF.md
# USB Host Frame Transaction Scheduler

This block keeps the host's pending bus transactions in two ordered request queues and decides which one goes out next. One queue is for periodic traffic (isochronous and interrupt). The other is for nonperiodic traffic (control and bulk). Software pushes 8-bit request entries into either queue. While a frame is open, the scheduler offers one request at a time to a transaction engine over a valid/ready handshake. When the engine returns a done pulse, the issued entry leaves its queue.

Each start-of-frame pulse takes a snapshot of how many periodic requests are waiting. Those requests are issued before any nonperiodic request. Periodic requests pushed after the pulse wait for the next frame. The end-of-frame pulse closes the frame. If any periodic request from the snapshot is still unfinished at that point, a sticky incomplete flag is raised.

Status outputs give each queue's free-entry count and its head entry. They also carry sticky per-queue overflow flags and the incomplete flag. All three flags are cleared by writing 1.

Top module: `usb_frame_sched`

## Requirements
- R1: After reset both free counts read 8, req_valid_o is low, and ovf_o and incomp_o are zero.
- R2: Each queue holds at most 8 entries, and its free count always equals 8 minus the number of entries it holds.
- R3: A push into a full queue stores nothing and sets that queue's sticky overflow bit (ovf_o bit 0 for periodic, bit 1 for nonperiodic).
- R4: Entries leave each queue in push order, and the head output shows the oldest entry. Entries pass through unchanged in the format bit 7 token (1 = IN), bits 6:4 type, bits 3:0 channel.
- R5: Requests are offered only between a start-of-frame pulse and the next end-of-frame pulse. An offered request stays valid and unchanged until ready. After acceptance nothing further is offered until done, and done pops the queue the request came from.
- R6: The periodic entries present at a start-of-frame pulse are all issued before any nonperiodic entry. Periodic entries pushed later are not offered until a later frame.
- R7: A start-of-frame pulse makes periodic entries take priority again, even over a nonperiodic request that is already being offered. A nonperiodic request that was already accepted still completes, and its done pops the nonperiodic queue.
- R8: At an end-of-frame pulse, incomp_o is set if any snapshot periodic entry is still unfinished. A done that arrives in the same cycle counts as finished.
- R9: clr_i bits 0, 1 and 2 clear ovf_o bit 0, ovf_o bit 1 and incomp_o when written as 1. If a flag is set and cleared in the same cycle, the set wins.
- R10: A done pulse while no request is outstanding changes no queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| per_push_i | input | 1 | Push per_entry_i into the periodic queue |
| per_entry_i | input | 8 | Periodic request entry |
| np_push_i | input | 1 | Push np_entry_i into the nonperiodic queue |
| np_entry_i | input | 8 | Nonperiodic request entry |
| sof_i | input | 1 | Start-of-frame pulse |
| eof_i | input | 1 | End-of-frame pulse |
| req_valid_o | output | 1 | A request is offered |
| req_ready_i | input | 1 | Transaction engine accepts the offer |
| req_entry_o | output | 8 | Offered entry |
| req_periodic_o | output | 1 | The offered entry comes from the periodic queue |
| done_i | input | 1 | Accepted transaction finished |
| per_free_o | output | 4 | Free entries in the periodic queue |
| np_free_o | output | 4 | Free entries in the nonperiodic queue |
| per_head_o | output | 8 | Oldest periodic entry |
| np_head_o | output | 8 | Oldest nonperiodic entry |
| ovf_o | output | 2 | Sticky overflow flags: bit 0 periodic, bit 1 nonperiodic |
| incomp_o | output | 1 | Sticky incomplete-periodic flag |
| clr_i | input | 3 | Write-1 clear for ovf_o[0], ovf_o[1] and incomp_o |

## Verification
The end-of-frame check and the completion of the last snapshot periodic request can fall in the same cycle. The bench provokes this by holding done back until it can be driven together with the end-of-frame pulse, and it expects incomp_o to stay clear and the periodic queue to read empty. A start-of-frame pulse can also meet a nonperiodic request in two states. In the first, the request is still being offered, and the bench expects the offer to switch to periodic at once. In the second, the request has already been accepted, and the bench expects its done to free a nonperiodic slot before the periodic offer appears. Setting and clearing a sticky flag in the same cycle is driven as well, and the flag is expected to stay set.

// File: rtl/usb_sched_pkg.sv
package usb_sched_pkg;
  localparam int ENTRY_W = 8;
  localparam int Q_DEPTH = 8;
  localparam int NUM_FLAGS = 3;
  typedef logic [ENTRY_W-1:0] sched_entry_t;
endpackage

// File: rtl/usb_req_queue.sv
module usb_req_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] free_o,
  output logic             ovf_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign ovf_o   = push_i && full;
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign free_o  = CNT_W'(DEPTH) - cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_full_push_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full && !pop_i |=> cnt_q == $past(cnt_q));
  assert_no_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/usb_sched_arb.sv
module usb_sched_arb #(
  parameter int W     = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic             ready_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] per_count_i,
  input  logic             per_empty_i,
  input  logic             np_empty_i,
  input  logic [W-1:0]     per_head_i,
  input  logic [W-1:0]     np_head_i,
  output logic             valid_o,
  output logic [W-1:0]     entry_o,
  output logic             periodic_o,
  output logic             per_pop_o,
  output logic             np_pop_o,
  output logic             incomp_set_o
);
  logic             frame_q, busy_q, busy_per_q;
  logic [CNT_W-1:0] sched_q, sched_left;
  logic             pick_per, pick_np, accept, done_ok;

  assign pick_per   = (sched_q != '0) && !per_empty_i;
  assign pick_np    = (sched_q == '0) && !np_empty_i;
  assign valid_o    = frame_q && !busy_q && (pick_per || pick_np);
  assign entry_o    = pick_per ? per_head_i : np_head_i;
  assign periodic_o = pick_per;
  assign accept     = valid_o && ready_i;
  assign done_ok    = done_i && busy_q;
  assign per_pop_o  = done_ok && busy_per_q;
  assign np_pop_o   = done_ok && !busy_per_q;
  // a done landing with eof counts as finished
  assign sched_left = sched_q - CNT_W'(per_pop_o && (sched_q != '0));
  assign incomp_set_o = eof_i && (sched_left != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q    <= 1'b0;
      busy_q     <= 1'b0;
      busy_per_q <= 1'b0;
      sched_q    <= '0;
    end else begin
      if (sof_i)      frame_q <= 1'b1;
      else if (eof_i) frame_q <= 1'b0;

      if (sof_i)      sched_q <= per_count_i - CNT_W'(per_pop_o);
      else if (eof_i) sched_q <= '0;
      else            sched_q <= sched_left;

      if (accept) begin
        busy_q     <= 1'b1;
        busy_per_q <= pick_per;
      end else if (done_ok) begin
        busy_q <= 1'b0;
      end
    end
  end

  assert_hold_offer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !sof_i && !eof_i && !done_i
    |=> valid_o && entry_o == $past(entry_o));
  assert_closed_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i && !sof_i |=> !valid_o);
  assert_per_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i && per_count_i > CNT_W'(per_pop_o) |=> !(valid_o && !periodic_o));
endmodule

// File: rtl/usb_sched_flags.sv
module usb_sched_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        f_q <= 1'b0;
      else if (set_i[g])  f_q <= 1'b1;
      else if (clr_i[g])  f_q <= 1'b0;
    end
    assign flag_o[g] = f_q;

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> f_q);
    assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      f_q && !clr_i[g] |=> f_q);
  end
endmodule

// File: rtl/usb_frame_sched.sv
module usb_frame_sched
  import usb_sched_pkg::*;
#(
  parameter int DEPTH = Q_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               per_push_i,
  input  logic [ENTRY_W-1:0] per_entry_i,
  input  logic               np_push_i,
  input  logic [ENTRY_W-1:0] np_entry_i,
  input  logic               sof_i,
  input  logic               eof_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [ENTRY_W-1:0] req_entry_o,
  output logic               req_periodic_o,
  input  logic               done_i,
  output logic [CNT_W-1:0]   per_free_o,
  output logic [CNT_W-1:0]   np_free_o,
  output logic [ENTRY_W-1:0] per_head_o,
  output logic [ENTRY_W-1:0] np_head_o,
  output logic [1:0]         ovf_o,
  output logic               incomp_o,
  input  logic [2:0]         clr_i
);
  localparam int NQ = 2;  // index 0 periodic, 1 nonperiodic

  logic         q_push  [NQ];
  sched_entry_t q_data  [NQ];
  logic         q_pop   [NQ];
  sched_entry_t q_head  [NQ];
  logic         q_empty [NQ];
  logic [CNT_W-1:0] q_count [NQ];
  logic [CNT_W-1:0] q_free  [NQ];
  logic         q_ovf   [NQ];
  logic         incomp_set;
  logic [NUM_FLAGS-1:0] flags;

  assign q_push[0] = per_push_i;
  assign q_push[1] = np_push_i;
  assign q_data[0] = per_entry_i;
  assign q_data[1] = np_entry_i;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    usb_req_queue #(.DEPTH(DEPTH), .W(ENTRY_W)) u_queue (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (q_push[q]),
      .data_i  (q_data[q]),
      .pop_i   (q_pop[q]),
      .head_o  (q_head[q]),
      .empty_o (q_empty[q]),
      .count_o (q_count[q]),
      .free_o  (q_free[q]),
      .ovf_o   (q_ovf[q])
    );
  end

  usb_sched_arb #(.W(ENTRY_W), .CNT_W(CNT_W)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sof_i        (sof_i),
    .eof_i        (eof_i),
    .ready_i      (req_ready_i),
    .done_i       (done_i),
    .per_count_i  (q_count[0]),
    .per_empty_i  (q_empty[0]),
    .np_empty_i   (q_empty[1]),
    .per_head_i   (q_head[0]),
    .np_head_i    (q_head[1]),
    .valid_o      (req_valid_o),
    .entry_o      (req_entry_o),
    .periodic_o   (req_periodic_o),
    .per_pop_o    (q_pop[0]),
    .np_pop_o     (q_pop[1]),
    .incomp_set_o (incomp_set)
  );

  usb_sched_flags #(.N(NUM_FLAGS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({incomp_set, q_ovf[1], q_ovf[0]}),
    .clr_i  (clr_i),
    .flag_o (flags)
  );

  assign per_free_o = q_free[0];
  assign np_free_o  = q_free[1];
  assign per_head_o = q_head[0];
  assign np_head_o  = q_head[1];
  assign ovf_o      = flags[1:0];
  assign incomp_o   = flags[2];

  assert_incomp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    incomp_set |=> incomp_o);
  assert_offer_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_entry_o == (req_periodic_o ? per_head_o : np_head_o));
endmodule

// File: tb/usb_frame_sched_tb.sv
module usb_frame_sched_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       per_push = 0, np_push = 0, sof = 0, eof = 0, ready = 0, done = 0;
  logic [7:0] per_entry = 0, np_entry = 0;
  logic [2:0] clr = 0;
  logic       req_valid, req_periodic, incomp;
  logic [7:0] req_entry, per_head, np_head;
  logic [3:0] per_free, np_free;
  logic [1:0] ovf;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  usb_frame_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .per_push_i(per_push), .per_entry_i(per_entry),
    .np_push_i(np_push), .np_entry_i(np_entry),
    .sof_i(sof), .eof_i(eof),
    .req_valid_o(req_valid), .req_ready_i(ready),
    .req_entry_o(req_entry), .req_periodic_o(req_periodic),
    .done_i(done),
    .per_free_o(per_free), .np_free_o(np_free),
    .per_head_o(per_head), .np_head_o(np_head),
    .ovf_o(ovf), .incomp_o(incomp), .clr_i(clr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_per(input logic [7:0] e);
    per_push = 1; per_entry = e; tick(); per_push = 0;
  endtask

  task automatic push_np(input logic [7:0] e);
    np_push = 1; np_entry = e; tick(); np_push = 0;
  endtask

  task automatic pulse_sof();
    sof = 1; tick(); sof = 0;
  endtask

  task automatic pulse_eof();
    eof = 1; tick(); eof = 0;
  endtask

  task automatic issue_one(input string tag, input logic [7:0] e, input logic per);
    chk({tag, " valid"}, req_valid, 1);
    chk({tag, " entry"}, req_entry, e);
    chk({tag, " source"}, req_periodic, per);
    ready = 1; tick(); ready = 0;
    chk({tag, " busy no offer"}, req_valid, 0);
    done = 1; tick(); done = 0;
  endtask

  function automatic logic [7:0] per_e(input int i);
    return 8'h90 | 8'(i);
  endfunction

  function automatic logic [7:0] np_e(input int i);
    return 8'h20 | 8'(i) | ((i % 2 == 1) ? 8'h80 : 8'h00);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(); tick();
    // R1
    chk("R1 per_free", per_free, 8);
    chk("R1 np_free", np_free, 8);
    chk("R1 valid", req_valid, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 incomp", incomp, 0);
    rst_n = 1; tick();

    // R2/R3 fill periodic past full
    for (int i = 0; i < 9; i++) begin
      push_per(per_e(i));
      chk("R2 per_free", per_free, (i < 8) ? 7 - i : 0);
      chk("R4 per_head", per_head, per_e(0));
    end
    chk("R3 ovf per", ovf, 2'b01);
    for (int i = 0; i < 8; i++) begin
      push_np(np_e(i));
      chk("R2 np_free", np_free, 7 - i);
    end
    chk("R3 no np ovf", ovf, 2'b01);
    chk("R4 np_head", np_head, np_e(0));
    clr = 3'b001; tick(); clr = 0;
    chk("R9 clear ovf", ovf, 0);
    chk("R5 no frame no offer", req_valid, 0);

    // R5/R6 frame drain
    pulse_sof();
    chk("R5 hold valid", req_valid, 1);
    tick();
    chk("R5 hold entry", req_entry, per_e(0));
    issue_one("R6 per0", per_e(0), 1);
    chk("R5 pop per", per_free, 1);
    push_per(8'hA5);
    chk("R2 refill", per_free, 0);
    for (int i = 1; i < 8; i++) issue_one("R4 per order", per_e(i), 1);
    for (int i = 0; i < 8; i++) begin
      issue_one("R6 np order", np_e(i), 0);
      chk("R2 np_free drain", np_free, i + 1);
    end
    chk("R6 late per waits", req_valid, 0);
    chk("R6 late per held", per_free, 7);
    pulse_eof();
    chk("R8 no incomp", incomp, 0);

    // R8 coincident done and eof
    pulse_sof();
    chk("R6 late per next frame", req_entry, 8'hA5);
    ready = 1; tick(); ready = 0;
    done = 1; eof = 1; tick(); done = 0; eof = 0;
    chk("R8 done with eof", incomp, 0);
    chk("R8 per emptied", per_free, 8);

    // R8/R9 incomplete, set vs clear
    push_per(8'h91); push_per(8'h92);
    pulse_sof();
    pulse_eof();
    chk("R8 incomp set", incomp, 1);
    chk("R5 closed frame", req_valid, 0);
    pulse_sof();
    eof = 1; clr = 3'b100; tick(); eof = 0; clr = 0;
    chk("R9 set wins", incomp, 1);
    clr = 3'b100; tick(); clr = 0;
    chk("R9 clear incomp", incomp, 0);
    pulse_sof();
    issue_one("R4 p91", 8'h91, 1);
    issue_one("R4 p92", 8'h92, 1);
    pulse_eof();
    chk("R8 clean frame", incomp, 0);

    // R7 preemption
    push_np(8'h33);
    pulse_sof();
    chk("R7 np offer", req_entry, 8'h33);
    chk("R7 np src", req_periodic, 0);
    push_per(8'h94);
    chk("R6 mid push no preempt", req_periodic, 0);
    pulse_sof();
    chk("R7 sof preempts", req_periodic, 1);
    issue_one("R7 p94", 8'h94, 1);
    chk("R7 np again", req_entry, 8'h33);
    ready = 1; tick(); ready = 0;
    push_per(8'h95);
    pulse_sof();
    chk("R7 busy no offer", req_valid, 0);
    chk("R7 np still held", np_free, 7);
    done = 1; tick(); done = 0;
    chk("R7 np popped", np_free, 8);
    issue_one("R7 p95", 8'h95, 1);
    pulse_eof();

    // R10 stray done
    push_np(8'h55);
    done = 1; tick(); done = 0;
    chk("R10 np_free", np_free, 7);
    chk("R10 np_head", np_head, 8'h55);
    chk("R10 per_free", per_free, 8);
    pulse_sof();
    issue_one("R10 drain", 8'h55, 0);
    pulse_eof();
    chk("R2 all free", np_free, 8);

    finish_run();
  end
endmodule